// File: doc/BRIEF.md
# Parallel NOR Flash Boot Sequencer

This block sits on the host side of a parallel NOR flash. It keeps the flash out of use until both supplies are good and settled, then drives the flash reset line through a low phase and a high phase, holds chip-enable inactive for a short guard time, and only then raises a level grant that lets the memory controller start its first access. The same sequence, without the supply setup wait, runs again when the system asks for a warm reset.

The two power-good inputs are asynchronous and each passes through its own synchronizer. Every duration is a parameter in clock cycles. The high phase of reset is stretched when needed, so that the low phase plus the high phase always covers the minimum time from reset falling to chip-enable falling. Outside the granted state, the sequencer forces chip-enable inactive whatever the memory controller drives. While granted, the controller's chip-enable passes straight through. Losing either supply at any point throws the sequence back to its start.

Top module: `nor_boot_seq`

## Requirements
- R1: While the system reset is low and right after it is released, flash_rst_n is 0, flash_ce_n is 1 and access_grant is 0.
- R2: Each power-good input passes through SYNC_STAGES flops. The setup wait of SETUP_CYC cycles starts only once both synchronized inputs are high, and one supply alone never starts the sequence.
- R3: After the setup wait, flash_rst_n stays low for RST_LOW_CYC more cycles. On power-up it therefore rises SYNC_STAGES+1+SETUP_CYC+RST_LOW_CYC cycles after the later power-good input goes high.
- R4: The reset high phase lasts max(RST_HIGH_CYC, RPH_CYC-RST_LOW_CYC) cycles, so the low phase plus the high phase is never shorter than RPH_CYC.
- R5: After the high phase, chip-enable is held inactive for CE_HIGH_CYC more cycles, and then access_grant goes to 1.
- R6: flash_ce_n is 1 whenever access_grant is 0, whatever mc_ce_n does. While access_grant is 1, flash_ce_n equals mc_ce_n in the same cycle.
- R7: A warm_req seen while granted drops access_grant and flash_rst_n on the next cycle. The low, high and chip-enable guard phases then run again without a setup wait.
- R8: warm_req has no effect while the sequence is still in progress: output edges keep their timing.
- R9: When either synchronized power-good is low, the next cycle has flash_rst_n 0 and access_grant 0. The whole sequence, including the setup wait, restarts once both are high again. A one-cycle glitch counts as a loss.
- R10: access_grant is a level output. It stays 1 for as long as both supplies stay good and no warm_req arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| pg_core | input | 1 | Core supply power-good, asynchronous |
| pg_io | input | 1 | I/O supply power-good, asynchronous |
| warm_req | input | 1 | Warm reset request, single-cycle pulse |
| mc_ce_n | input | 1 | Chip-enable from the memory controller, active low |
| flash_rst_n | output | 1 | Reset line to the flash, active low |
| flash_ce_n | output | 1 | Chip-enable to the flash, active low |
| access_grant | output | 1 | High while the controller may access the flash |

## Verification
The bench predicts the exact cycle of every output edge and compares each edge against that prediction. A design that left out the synchronizer or the setup count would show its reset edge too early. One that skipped the stretch of the high phase would grant about four cycles early. The bench drives chip-enable low while reset is still active, and pulses warm_req in the middle of the sequence; a leaking gate or an unguarded request would produce an edge with no prediction to match it. It also drops a supply for a single cycle while granted and drops one again during the reset high phase. A design that finished the sequence anyway, or skipped the setup wait on the way back, would place its edges in the wrong cycles.

// File: rtl/nor_boot_pkg.sv
package nor_boot_pkg;

    typedef enum logic [2:0] {
        ST_PWR_WAIT = 3'd0,
        ST_SETUP    = 3'd1,
        ST_RST_LO   = 3'd2,
        ST_RST_HI   = 3'd3,
        ST_CE_HI    = 3'd4,
        ST_READY    = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       rst_n;
        logic       grant;
    } seq_regs_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nor_boot_sync.sv
module nor_boot_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_in;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nor_boot_timer.sv
module nor_boot_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // a running count never moves up without a load (R4)
    AST_TIMER_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));  // R4
endmodule

// File: rtl/nor_boot_seq.sv
module nor_boot_seq
    import nor_boot_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned SETUP_CYC    = 30000,
    parameter int unsigned RST_LOW_CYC  = 20,
    parameter int unsigned RST_HIGH_CYC = 5,
    parameter int unsigned RPH_CYC      = 3500,
    parameter int unsigned CE_HIGH_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_core,
    input  logic pg_io,
    input  logic warm_req,
    input  logic mc_ce_n,
    output logic flash_rst_n,
    output logic flash_ce_n,
    output logic access_grant
);
    localparam int unsigned N_SUP    = 2;
    localparam int unsigned HIGH_CYC = max2(RST_HIGH_CYC,
                                            (RPH_CYC > RST_LOW_CYC) ? RPH_CYC - RST_LOW_CYC : 0);
    localparam int unsigned MAX_CYC  = max2(max2(SETUP_CYC, RST_LOW_CYC), max2(HIGH_CYC, CE_HIGH_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
    localparam int unsigned CHK_W    = CNT_W + 2;

    // ---------------- supply synchronizers ----------------
    logic [N_SUP-1:0] pg_raw;
    logic [N_SUP-1:0] pg_sync;
    logic             pg_ok;

    assign pg_raw = {pg_io, pg_core};

    generate
        for (genvar g = 0; g < N_SUP; g++) begin : g_sup
            nor_boot_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (pg_raw[g]),
                .sync_out (pg_sync[g])
            );
        end
    endgenerate

    assign pg_ok = &pg_sync;

    // ---------------- phase timer ----------------
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    nor_boot_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // ---------------- sequencer ----------------
    seq_regs_t seq_d;
    seq_regs_t seq_q;

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;

        case (seq_q.state)
            ST_PWR_WAIT: begin
                if (pg_ok) begin
                    seq_d.state = ST_SETUP;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    seq_d.state = ST_RST_LO;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(RST_LOW_CYC - 1);
                end
            end
            ST_RST_LO: begin
                if (tmr_done) begin
                    seq_d.state = ST_RST_HI;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(HIGH_CYC - 1);
                end
            end
            ST_RST_HI: begin
                if (tmr_done) begin
                    seq_d.state = ST_CE_HI;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(CE_HIGH_CYC - 1);
                end
            end
            ST_CE_HI: begin
                if (tmr_done) seq_d.state = ST_READY;
            end
            ST_READY: begin
                if (warm_req) begin
                    seq_d.state = ST_RST_LO;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(RST_LOW_CYC - 1);
                end
            end
            default: seq_d.state = ST_PWR_WAIT;
        endcase

        // supply loss overrides every phase
        if (!pg_ok) begin
            seq_d.state = ST_PWR_WAIT;
            tmr_load    = 1'b1;
            tmr_val     = '0;
        end

        seq_d.rst_n = (seq_d.state == ST_RST_HI) || (seq_d.state == ST_CE_HI) ||
                      (seq_d.state == ST_READY);
        seq_d.grant = (seq_d.state == ST_READY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_PWR_WAIT;
            seq_q.rst_n <= 1'b0;
            seq_q.grant <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign flash_rst_n  = seq_q.rst_n;
    assign access_grant = seq_q.grant;
    assign flash_ce_n   = seq_q.grant ? mc_ce_n : 1'b1;

    // ---------------- checker counters and assertions ----------------
    logic [CHK_W-1:0] lo_run_q, hi_run_q, pg_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run_q <= '0;
            hi_run_q <= '0;
            pg_run_q <= '0;
        end else begin
            lo_run_q <= flash_rst_n ? '0 : ((&lo_run_q) ? lo_run_q : lo_run_q + 1'b1);
            hi_run_q <= !flash_rst_n ? '0 : ((&hi_run_q) ? hi_run_q : hi_run_q + 1'b1);
            pg_run_q <= !pg_ok ? '0 : ((&pg_run_q) ? pg_run_q : pg_run_q + 1'b1);
        end
    end

    AST_SETUP_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_rst_n) |-> (pg_run_q >= CHK_W'(SETUP_CYC + RST_LOW_CYC)));  // R2
    AST_RST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_rst_n) |-> (lo_run_q >= CHK_W'(RST_LOW_CYC)));  // R3
    AST_HIGH_PLUS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_grant) |-> (hi_run_q >= CHK_W'(HIGH_CYC + CE_HIGH_CYC)));  // R5
    AST_PG_LOSS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_ok |=> (!flash_rst_n && !access_grant));  // R9
    AST_WARM_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (access_grant && warm_req && pg_ok) |=> (!flash_rst_n && !access_grant));  // R7
    AST_CE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_rst_n |-> flash_ce_n);  // R6
endmodule

// File: tb/nor_boot_seq_tb.sv
module nor_boot_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P_SYNC  = 2;
    localparam int P_SETUP = 20;
    localparam int P_RL    = 4;
    localparam int P_RH    = 2;
    localparam int P_RPH   = 10;
    localparam int P_CEH   = 3;
    // expected derived timings, from the requirements
    localparam int HI_LEN  = (P_RH > P_RPH - P_RL) ? P_RH : P_RPH - P_RL;  // R4
    localparam int RISE_PU = P_SYNC + 1 + P_SETUP + P_RL;                  // R3
    localparam int GRANT_AFTER_RISE = HI_LEN + P_CEH;                      // R5
    localparam int LOSS_LAT = P_SYNC + 1;                                  // R9

    logic clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic pg_core = 1'b0, pg_io = 1'b0, warm_req = 1'b0, mc_ce_n = 1'b1;
    logic flash_rst_n, flash_ce_n, access_grant;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [2:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t e;
    logic [2:0] prev = 3'b010;
    logic [2:0] cur;

    nor_boot_seq #(
        .SYNC_STAGES(P_SYNC), .SETUP_CYC(P_SETUP), .RST_LOW_CYC(P_RL),
        .RST_HIGH_CYC(P_RH), .RPH_CYC(P_RPH), .CE_HIGH_CYC(P_CEH)
    ) u_dut (
        .clk(clk), .rst_n(sys_rst_n), .pg_core(pg_core), .pg_io(pg_io),
        .warm_req(warm_req), .mc_ce_n(mc_ce_n), .flash_rst_n(flash_rst_n),
        .flash_ce_n(flash_ce_n), .access_grant(access_grant)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: every output edge must match the front of the queue
    always @(negedge clk) begin
        if (sys_rst_n && !done) begin
            cur = {flash_rst_n, flash_ce_n, access_grant};
            if (cur !== prev) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected edge (R6/R8): cycle %0d value %b, expected no change from %b",
                             cyc, cur, prev);
                end else begin
                    e = exp_q.pop_front();
                    if (e.at != cyc || e.val !== cur) begin
                        n_bad++;
                        $display("FAIL %s: cycle %0d value %b, expected cycle %0d value %b",
                                 e.tag, cyc, cur, e.at, e.val);
                    end
                end
                prev = cur;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic push_exp(input int at, input logic [2:0] v, input string tag);
        exp_t x;
        x.at = at; x.val = v; x.tag = tag;
        exp_q.push_back(x);
    endtask

    task automatic check_now(input logic [2:0] v, input string tag);
        n_chk++;
        if ({flash_rst_n, flash_ce_n, access_grant} !== v) begin
            n_bad++;
            $display("FAIL %s: value %b, expected %b", tag, {flash_rst_n, flash_ce_n, access_grant}, v);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: cycle %0d, expected run to end earlier", cyc);
        finish_run();
    end

    initial begin
        int c;
        step(3);
        check_now(3'b010, "R1 in reset");
        sys_rst_n = 1'b1;
        step(1);
        check_now(3'b010, "R1 after release");

        // one supply alone must not start anything (R2)
        pg_core = 1'b1;
        step(12);
        check_now(3'b010, "R2 single supply");

        // power-up: R2 R3 R4 R5, mc_ce_n ignored (R6), warm ignored (R8)
        c = cyc;
        pg_io = 1'b1;
        push_exp(c + RISE_PU, 3'b110, "R3 power-up reset rise");
        push_exp(c + RISE_PU + GRANT_AFTER_RISE, 3'b101, "R4 R5 grant with ce passthrough");
        step(25);
        mc_ce_n = 1'b0;
        step(5);
        warm_req = 1'b1;
        step(1);
        warm_req = 1'b0;
        step(9);
        check_now(3'b101, "R10 grant level held");

        // passthrough both ways (R6)
        c = cyc;
        mc_ce_n = 1'b1;
        push_exp(c, 3'b111, "R6 ce follows high");
        step(2);
        mc_ce_n = 1'b0;
        push_exp(c + 2, 3'b101, "R6 ce follows low");
        step(3);

        // warm reset (R7)
        c = cyc;
        warm_req = 1'b1;
        push_exp(c + 1, 3'b010, "R7 warm drop");
        push_exp(c + 1 + P_RL, 3'b110, "R7 warm reset rise");
        push_exp(c + 1 + P_RL + GRANT_AFTER_RISE, 3'b101, "R7 warm regrant");
        step(1);
        warm_req = 1'b0;
        step(16);

        // supply loss while granted and full restart (R9)
        c = cyc;
        pg_io = 1'b0;
        push_exp(c + LOSS_LAT, 3'b010, "R9 loss drop");
        step(6);
        c = cyc;
        pg_io = 1'b1;
        push_exp(c + RISE_PU, 3'b110, "R9 restart rise");
        push_exp(c + RISE_PU + GRANT_AFTER_RISE, 3'b101, "R9 restart grant");
        step(40);

        // one-cycle glitch, then a loss in the high phase (R9)
        c = cyc;
        pg_core = 1'b0;
        push_exp(c + LOSS_LAT, 3'b010, "R9 glitch drop");
        step(1);
        pg_core = 1'b1;
        push_exp(c + 1 + RISE_PU, 3'b110, "R9 glitch restart rise");
        step(1 + RISE_PU + 1);
        pg_io = 1'b0;
        push_exp(cyc + LOSS_LAT, 3'b010, "R9 loss in high phase");
        step(6);
        c = cyc;
        pg_io = 1'b1;
        push_exp(c + RISE_PU, 3'b110, "R9 final rise");
        push_exp(c + RISE_PU + GRANT_AFTER_RISE, 3'b101, "R9 final grant");
        step(45);

        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R3/R5 missing edges: %0d pending, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule